// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor

This unit turns an addressing mode, the operand bytes that follow an opcode, the current program counter and the two index registers into the 16-bit effective address. It also returns the program counter advanced past the operand bytes, the number of operand bytes the mode consumes, and the base cycle count a read instruction takes in that mode. Instruction decode and execution sit outside the block.

A request is made by pulsing `start` with all inputs valid in the same cycle. The inputs are captured on that edge. Modes that need no memory access finish on the next edge. The two indirect modes fetch a two-byte pointer from page zero through a byte read port before they finish. The read port has a fixed latency of one cycle: data for a request made in one cycle is presented on `rd_data` in the following cycle. A `done` pulse marks the cycle in which the result outputs are valid. The outputs hold their values until the next accepted request.

Top module: `ea_gen`

## Requirements
- R1: After reset `done` and `rd_req` are 0, and `ea`, `next_pc`, `opnd_bytes` and `base_cycles` are 0.
- R2: The mode is encoded as follows: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 relative, 5 absolute, 6 absolute + X, 7 absolute + Y, 8 indexed-indirect by X, 9 indirect-indexed by Y. Codes 10 to 15 consume 0 bytes, report 2 base cycles and give `ea` = `pc`.
- R3: In zero page modes, `ea` is {8'h00, (opnd_lo + index) mod 256}. The index is 0, X or Y. The high byte is always 0. These modes consume 1 byte and report 3 base cycles unindexed and 4 indexed.
- R4: In absolute modes, `ea` is ({opnd_hi, opnd_lo} + index) mod 65536. The index is 0, X or Y. These modes consume 2 bytes and report 4 base cycles.
- R5: Indexed-indirect by X reads the pointer low byte at page-zero address (opnd_lo + X) mod 256, then the high byte at (opnd_lo + X + 1) mod 256. `ea` is that pointer. The mode consumes 1 byte and reports 6 base cycles.
- R6: Indirect-indexed by Y reads the pointer low byte at page-zero address opnd_lo, then the high byte at (opnd_lo + 1) mod 256. `ea` is (pointer + Y) mod 65536. The mode consumes 1 byte and reports 5 base cycles.
- R7: Immediate mode gives `ea` = `pc`, the address of the operand byte. It consumes 1 byte and reports 2 base cycles.
- R8: Relative mode consumes 1 byte and reports 2 base cycles. When `take_branch` is 1, `ea` is pc + 1 plus the sign-extended opnd_lo, mod 65536. Otherwise `ea` is pc + 1.
- R9: `next_pc` equals (pc + operand bytes) mod 65536.
- R10: `done` rises on the first edge after an accepted `start` for the non-indirect modes, and on the fourth edge for the two indirect modes. Both pointer reads are issued on consecutive cycles. `done` is never high while a pointer fetch is in progress.
- R11: A `start` pulse that arrives while a pointer fetch is in progress is ignored. It neither changes the pending result nor produces an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request; inputs are captured when it is accepted |
| mode | input | 4 | Addressing mode code |
| pc | input | 16 | Address of the first operand byte |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte (absolute modes) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| take_branch | input | 1 | Branch condition result for relative mode |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| next_pc | output | 16 | Program counter past the operand |
| opnd_bytes | output | 2 | Operand bytes consumed |
| base_cycles | output | 3 | Base cycle count for a read instruction |

## Verification
The assertions assume two things about the environment. Memory returns read data exactly one cycle after each request. `start` is only meaningful when the block is idle or in its done cycle. The bench's memory model answers every request on the following edge from a computed byte pattern, so pointer values are deterministic. Random requests are issued only after the previous `done` has been seen, which keeps the stimulus inside these assumptions. One directed case deliberately pulses `start` during a fetch to show that it is ignored.

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [15:0] pc,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic        take_branch,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        done,
  output logic [15:0] ea,
  output logic [15:0] next_pc,
  output logic [1:0]  opnd_bytes,
  output logic [2:0]  base_cycles
);
  localparam logic [3:0] M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3,
                         M_REL = 4'd4, M_ABS = 4'd5, M_ABSX = 4'd6, M_ABSY = 4'd7,
                         M_INDX = 4'd8, M_INDY = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_PLO, S_PHI, S_WAIT} state_t;
  state_t st;

  logic [3:0]  mode_q;
  logic [7:0]  ptr_q, yadd_q, plo_q;
  logic [7:0]  zx, zy;
  logic [15:0] absw, dir_ea, pc_nx;
  logic [1:0]  nb;
  logic [2:0]  nc;
  logic        indirect;

  assign zx   = opnd_lo + idx_x;
  assign zy   = opnd_lo + idx_y;
  assign absw = {opnd_hi, opnd_lo};
  assign pc_nx = pc + {14'd0, nb};
  assign indirect = (mode == M_INDX) || (mode == M_INDY);

  always_comb begin
    nb = 2'd1;
    nc = 3'd2;
    dir_ea = pc;
    case (mode)
      M_IMM:  begin nb = 2'd1; nc = 3'd2; dir_ea = pc; end
      M_ZP:   begin nb = 2'd1; nc = 3'd3; dir_ea = {8'h00, opnd_lo}; end
      M_ZPX:  begin nb = 2'd1; nc = 3'd4; dir_ea = {8'h00, zx}; end
      M_ZPY:  begin nb = 2'd1; nc = 3'd4; dir_ea = {8'h00, zy}; end
      M_REL:  begin
        nb = 2'd1; nc = 3'd2;
        dir_ea = take_branch ? (pc + 16'd1 + {{8{opnd_lo[7]}}, opnd_lo}) : (pc + 16'd1);
      end
      M_ABS:  begin nb = 2'd2; nc = 3'd4; dir_ea = absw; end
      M_ABSX: begin nb = 2'd2; nc = 3'd4; dir_ea = absw + {8'h00, idx_x}; end
      M_ABSY: begin nb = 2'd2; nc = 3'd4; dir_ea = absw + {8'h00, idx_y}; end
      M_INDX: begin nb = 2'd1; nc = 3'd6; dir_ea = pc; end
      M_INDY: begin nb = 2'd1; nc = 3'd5; dir_ea = pc; end
      default: begin nb = 2'd0; nc = 3'd2; dir_ea = pc; end
    endcase
  end

  assign rd_req  = (st == S_PLO) || (st == S_PHI);
  assign rd_addr = {8'h00, (st == S_PHI) ? ptr_q + 8'd1 : ptr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      ea <= '0;
      next_pc <= '0;
      opnd_bytes <= '0;
      base_cycles <= '0;
      mode_q <= '0;
      ptr_q <= '0;
      yadd_q <= '0;
      plo_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          next_pc <= pc_nx;
          opnd_bytes <= nb;
          base_cycles <= nc;
          mode_q <= mode;
          if (indirect) begin
            ptr_q  <= (mode == M_INDX) ? zx : opnd_lo;
            yadd_q <= (mode == M_INDY) ? idx_y : 8'h00;
            st <= S_PLO;
          end else begin
            ea <= dir_ea;
            done <= 1'b1;
          end
        end
        S_PLO: st <= S_PHI;
        S_PHI: begin
          plo_q <= rd_data;
          st <= S_WAIT;
        end
        S_WAIT: begin
          ea <= {rd_data, plo_q} + {8'h00, yadd_q};
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: no result while the pointer fetch is busy
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !done);
  // R10: pointer reads come as a back-to-back pair
  a_r10_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |=> rd_req);
  // R5/R6: high pointer byte address follows the low one within page zero
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PHI) |-> (rd_addr[7:0] == $past(rd_addr[7:0]) + 8'd1));
  // R11: a busy-time start leaves the captured request untouched
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(next_pc) && $stable(mode_q));
  // R3: zero page results stay in page zero
  a_r3_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY)) |-> (ea[15:8] == 8'h00));
  // R4: absolute modes consume two operand bytes
  a_r4_abs_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_ABS || mode_q == M_ABSX || mode_q == M_ABSY)) |-> (opnd_bytes == 2'd2));
endmodule

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, take_branch = 1'b0;
  logic [3:0] mode = '0;
  logic [15:0] pc = '0;
  logic [7:0] opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic rd_req, done;
  logic [15:0] rd_addr, ea, next_pc;
  logic [7:0] rd_data = '0;
  logic [1:0] opnd_bytes;
  logic [2:0] base_cycles;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ea_gen dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .take_branch(take_branch), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .ea(ea), .next_pc(next_pc), .opnd_bytes(opnd_bytes), .base_cycles(base_cycles));

  function automatic logic [7:0] memb(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5B;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memb(rd_addr);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] m, input logic [15:0] p, input logic [7:0] lo, hi, x, y,
                       input logic tk, output logic [15:0] e, output logic [1:0] b,
                       output logic [2:0] c, output int lat, output string tag);
    logic [7:0] pa;
    logic [15:0] ptr;
    lat = 1; b = 1; c = 2; e = p; tag = "R2";
    case (m)
      4'd0: begin tag = "R7"; e = p; end
      4'd1: begin tag = "R3"; c = 3; e = {8'h00, lo}; end
      4'd2: begin tag = "R3"; c = 4; e = {8'h00, 8'(lo + x)}; end
      4'd3: begin tag = "R3"; c = 4; e = {8'h00, 8'(lo + y)}; end
      4'd4: begin tag = "R8"; e = tk ? 16'(p + 16'd1 + {{8{lo[7]}}, lo}) : 16'(p + 16'd1); end
      4'd5: begin tag = "R4"; b = 2; c = 4; e = {hi, lo}; end
      4'd6: begin tag = "R4"; b = 2; c = 4; e = 16'({hi, lo} + x); end
      4'd7: begin tag = "R4"; b = 2; c = 4; e = 16'({hi, lo} + y); end
      4'd8: begin
        tag = "R5"; c = 6; lat = 4; pa = lo + x;
        e = {memb({8'h00, 8'(pa + 8'd1)}), memb({8'h00, pa})};
      end
      4'd9: begin
        tag = "R6"; c = 5; lat = 4;
        ptr = {memb({8'h00, 8'(lo + 8'd1)}), memb({8'h00, lo})};
        e = ptr + {8'h00, y};
      end
      default: begin tag = "R2"; b = 0; c = 2; e = p; end
    endcase
  endtask

  task automatic issue(input logic [3:0] m, input logic [15:0] p, input logic [7:0] lo, hi, x, y,
                       input logic tk, input bit disturb);
    logic [15:0] e; logic [1:0] b; logic [2:0] c; int lat, seen; string tag;
    model(m, p, lo, hi, x, y, tk, e, b, c, lat, tag);
    mode = m; pc = p; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; take_branch = tk;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1;
    if (disturb) begin
      mode = 4'd1; pc = ~p; opnd_lo = ~lo; idx_y = ~y; start = 1'b1;
      @(negedge clk); start = 1'b0; seen++;
    end
    while (!done && seen < 20) begin @(negedge clk); seen++; end
    chk("R10", "latency", 16'(seen), 16'(lat));
    chk(tag, "ea", ea, e);
    chk("R9", "next_pc", next_pc, 16'(p + b));
    chk(tag, "bytes", {14'd0, opnd_bytes}, {14'd0, b});
    chk(tag, "cycles", {13'd0, base_cycles}, {13'd0, c});
    if (disturb) begin
      int extra = 0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
      chk("R11", "extra done", 16'(extra), 16'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "rd_req", {15'd0, rd_req}, 16'd0);
    chk("R1", "ea", ea, 16'd0);
    chk("R1", "next_pc", next_pc, 16'd0);
    chk("R1", "bytes/cycles", {11'd0, opnd_bytes, base_cycles}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(4'd0, 16'h8000, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    issue(4'd2, 16'h1234, 8'hF0, 8'h77, 8'h20, 8'h00, 1'b0, 1'b0);
    issue(4'd3, 16'h1234, 8'h80, 8'h77, 8'h00, 8'h90, 1'b0, 1'b0);
    issue(4'd1, 16'h0200, 8'hAB, 8'hCD, 8'h01, 8'h02, 1'b0, 1'b0);
    issue(4'd6, 16'hFFFF, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0);
    issue(4'd7, 16'h4000, 8'hF0, 8'h12, 8'h00, 8'h20, 1'b0, 1'b0);
    issue(4'd5, 16'hFFFE, 8'h34, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0);
    issue(4'd4, 16'h8010, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    issue(4'd4, 16'h8010, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    issue(4'd4, 16'hFFF0, 8'h7F, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    issue(4'd8, 16'h0300, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    issue(4'd8, 16'h0300, 8'hF0, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0);
    issue(4'd9, 16'h0300, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0);
    issue(4'd12, 16'h5555, 8'h01, 8'h02, 8'h03, 8'h04, 1'b0, 1'b0);
    issue(4'd9, 16'h0700, 8'h40, 8'h00, 8'h00, 8'h33, 1'b0, 1'b1);
    for (int n = 0; n < 400; n++)
      issue(4'($urandom % 16), 16'($urandom), 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom), 1'($urandom), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule